// File: doc/BRIEF.md
# Banked DMA Channel Register File

This block is the register front end of a multi-channel DMA engine that moves data between tightly coupled memory and external memory. A processor-side access carries a 4-bit register select, a direction, a mode flag and write data. The block decodes the access, checks it, and answers one cycle later with an acknowledge, a trap flag and read data. The transfer datapath is not part of this block. It receives start, stop and clear strobes and reports its per-channel queued, running, interrupt, done and error state back as inputs.

Most registers exist once per channel: control, the three address registers, the context ID, the channel status and the command registers. A global channel-number register decides which copy an access reaches. A global user-permission register decides which operations code running in unprivileged mode may perform. Any access that is not allowed does not complete. It returns a trap instead, changes no state and issues no strobe.

Top module: `dma_bank_regs`

## Requirements
- R1: After reset, the channel number, the user-permission register and every channel's control, address and context registers read as zero, every channel status reads zero, and ack_o, trap_o, rdata_o and all strobes are low.
- R2: An access presented with req_i high is answered on the next cycle. ack_o is high for one cycle. On a legal read, rdata_o holds the register value. On a write or a trapped access, rdata_o is zero. Read/write selects are 8 user-permission (4 bits), 9 channel number (4 bits), 10 control, 11 internal start address, 12 external start address, 13 internal end address and 14 context ID (32 bits each).
- R3: Selects 4, 5, 6, 7 and 10 to 14 reach only the bank of the channel held in the channel-number register. A write to one bank leaves the other banks unchanged.
- R4: Select 0 reads a bitmap with one bit set per implemented channel. Selects 1, 2 and 3 read the live queued_i, running_i and irq_i vectors, sampled at the edge that accepts the access.
- R5: A legal write to select 5 (start), 6 (stop) or 7 (clear) raises the matching strobe bit of the selected channel for exactly one cycle, together with ack_o. The write data is ignored.
- R6: Channel status (select 4) is bit 0 done and bit 1 error. Each bit is set by a one-cycle pulse on done_evt_i or err_evt_i for that channel and stays set until a clear command. A clear command zeroes it, but an event in the same cycle as the clear leaves its bit set.
- R7: A write to selects 0 to 4, a read of selects 5 to 7, and any access to select 15 trap.
- R8: An access to a banked select while the channel number is not below the channel count traps. Selects 0 to 3, 8 and 9 remain usable.
- R9: In user mode (user_i high), the user-permission bits gate access. Bit 0 allows selects 5 to 7, bit 1 allows reads of selects 0 to 4, bit 2 allows writes of selects 10 to 14, and bit 3 allows reads of selects 10 to 14. An access whose bit is clear traps.
- R10: In user mode, writes to selects 8 and 9 always trap and reads of them are allowed.
- R11: A trapped access changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| write_i | input | 1 | 1 = write, 0 = read |
| user_i | input | 1 | Access issued in unprivileged mode |
| sel_i | input | 4 | Register select |
| wdata_i | input | DATA_W | Write data |
| queued_i | input | NCH | Engine: channel queued |
| running_i | input | NCH | Engine: channel running |
| irq_i | input | NCH | Engine: channel interrupting |
| done_evt_i | input | NCH | Engine: transfer done pulse |
| err_evt_i | input | NCH | Engine: transfer error pulse |
| ack_o | output | 1 | Access answered |
| trap_o | output | 1 | Access refused, undefined-instruction trap |
| rdata_o | output | DATA_W | Read data |
| start_o | output | NCH | Start strobe per channel |
| stop_o | output | NCH | Stop strobe per channel |
| clr_o | output | NCH | Clear strobe per channel |

## Verification
The bench targets bank crosstalk. A design that ignores the channel number would show channel 1's control value when channel 0 is read back. It also drives a clear in the same cycle as a done event. A design that gives clear priority would lose that event and read status 0 where 1 is expected. It moves the channel number out of range and sweeps the user-permission bits one at a time. A missing check in either case would show up as an acknowledged access with no trap, or as a strobe that fires. After each trapped write, a privileged read checks that the stored value was not overwritten.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  typedef enum logic [3:0] {
    SEL_PRESENT = 4'd0,
    SEL_QUEUED  = 4'd1,
    SEL_RUNNING = 4'd2,
    SEL_IRQ     = 4'd3,
    SEL_CSTAT   = 4'd4,
    SEL_START   = 4'd5,
    SEL_STOP    = 4'd6,
    SEL_CLEAR   = 4'd7,
    SEL_UPERM   = 4'd8,
    SEL_CHNUM   = 4'd9,
    SEL_CTRL    = 4'd10,
    SEL_ISTART  = 4'd11,
    SEL_ESTART  = 4'd12,
    SEL_IEND    = 4'd13,
    SEL_CTXID   = 4'd14,
    SEL_NONE    = 4'd15
  } reg_sel_e;

  localparam int UPERM_W   = 4;
  localparam int UP_CMD    = 0;
  localparam int UP_STAT_R = 1;
  localparam int UP_BANK_W = 2;
  localparam int UP_BANK_R = 3;
  localparam int BANK_REGS = 5;
  localparam int STAT_W    = 2;

  typedef struct packed {
    logic trap;
    logic wr_uperm;
    logic wr_chnum;
    logic wr_bank;
    logic cmd_start;
    logic cmd_stop;
    logic cmd_clear;
  } acc_dec_t;
endpackage

// File: rtl/dma_acc_decode.sv
module dma_acc_decode
  import dma_regs_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int CHNUM_W = 4
) (
  input  logic               req_i,
  input  logic               write_i,
  input  logic               user_i,
  input  logic [3:0]         sel_i,
  input  logic [UPERM_W-1:0] uperm_i,
  input  logic [CHNUM_W-1:0] chnum_i,
  output acc_dec_t           dec_o
);
  logic is_ro, is_cmd, is_bank_rw, is_glob_rw, is_none, banked;
  logic dir_bad, range_bad, priv_bad, ok;

  always_comb begin
    is_ro      = sel_i <= 4'(SEL_CSTAT);
    is_cmd     = sel_i >= 4'(SEL_START) && sel_i <= 4'(SEL_CLEAR);
    is_glob_rw = sel_i == 4'(SEL_UPERM) || sel_i == 4'(SEL_CHNUM);
    is_bank_rw = sel_i >= 4'(SEL_CTRL) && sel_i <= 4'(SEL_CTXID);
    is_none    = sel_i == 4'(SEL_NONE);
    banked     = sel_i == 4'(SEL_CSTAT) || is_cmd || is_bank_rw;

    dir_bad   = (is_ro && write_i) || (is_cmd && !write_i) || is_none;
    range_bad = banked && ({1'b0, chnum_i} >= (CHNUM_W+1)'(NCH));
    priv_bad  = user_i && (
                  (is_ro && !uperm_i[UP_STAT_R]) ||
                  (is_cmd && !uperm_i[UP_CMD]) ||
                  (is_bank_rw && write_i && !uperm_i[UP_BANK_W]) ||
                  (is_bank_rw && !write_i && !uperm_i[UP_BANK_R]) ||
                  (is_glob_rw && write_i));
    ok = req_i && !(dir_bad || range_bad || priv_bad);

    dec_o.trap      = req_i && !ok;
    dec_o.wr_uperm  = ok && write_i && sel_i == 4'(SEL_UPERM);
    dec_o.wr_chnum  = ok && write_i && sel_i == 4'(SEL_CHNUM);
    dec_o.wr_bank   = ok && write_i && is_bank_rw;
    dec_o.cmd_start = ok && sel_i == 4'(SEL_START);
    dec_o.cmd_stop  = ok && sel_i == 4'(SEL_STOP);
    dec_o.cmd_clear = ok && sel_i == 4'(SEL_CLEAR);
  end
endmodule

// File: rtl/dma_chan_bank.sv
module dma_chan_bank
  import dma_regs_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [2:0]                       wr_idx_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic                             clr_i,
  input  logic                             done_evt_i,
  input  logic                             err_evt_i,
  output logic [BANK_REGS-1:0][DATA_W-1:0] regs_o,
  output logic [STAT_W-1:0]                stat_o
);
  logic [BANK_REGS-1:0][DATA_W-1:0] regs_q;
  logic [STAT_W-1:0]                stat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < BANK_REGS; i++)
        if (wr_idx_i == 3'(i)) regs_q[i] <= wdata_i;
    end
  end

  // events set after clear so a coincident event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (clr_i ? '0 : stat_q) | {err_evt_i, done_evt_i};
  end

  assign regs_o = regs_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/dma_bank_regs.sv
module dma_bank_regs
  import dma_regs_pkg::*;
#(
  parameter int NCH     = 2,
  parameter int CHNUM_W = 4,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              write_i,
  input  logic              user_i,
  input  logic [3:0]        sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NCH-1:0]    queued_i,
  input  logic [NCH-1:0]    running_i,
  input  logic [NCH-1:0]    irq_i,
  input  logic [NCH-1:0]    done_evt_i,
  input  logic [NCH-1:0]    err_evt_i,
  output logic              ack_o,
  output logic              trap_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NCH-1:0]    start_o,
  output logic [NCH-1:0]    stop_o,
  output logic [NCH-1:0]    clr_o
);
  localparam int MIN_W = (NCH > CHNUM_W) ? NCH : CHNUM_W;

  logic [UPERM_W-1:0] uperm_q;
  logic [CHNUM_W-1:0] chnum_q;
  acc_dec_t           dec;
  logic [NCH-1:0]     ch_hit;
  logic [2:0]         bank_idx;

  logic [BANK_REGS-1:0][DATA_W-1:0] bank_regs [NCH];
  logic [STAT_W-1:0]                bank_stat [NCH];
  logic [BANK_REGS-1:0][DATA_W-1:0] cur_regs;
  logic [STAT_W-1:0]                cur_stat;
  logic [DATA_W-1:0]                rd_val;

  dma_acc_decode #(.NCH(NCH), .CHNUM_W(CHNUM_W)) u_dec (
    .req_i   (req_i),
    .write_i (write_i),
    .user_i  (user_i),
    .sel_i   (sel_i),
    .uperm_i (uperm_q),
    .chnum_i (chnum_q),
    .dec_o   (dec)
  );

  assign bank_idx = 3'(sel_i - 4'(SEL_CTRL));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_hit[c] = chnum_q == CHNUM_W'(c);
    dma_chan_bank #(.DATA_W(DATA_W)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_en_i    (dec.wr_bank && ch_hit[c]),
      .wr_idx_i   (bank_idx),
      .wdata_i    (wdata_i),
      .clr_i      (dec.cmd_clear && ch_hit[c]),
      .done_evt_i (done_evt_i[c]),
      .err_evt_i  (err_evt_i[c]),
      .regs_o     (bank_regs[c]),
      .stat_o     (bank_stat[c])
    );
  end

  always_comb begin
    cur_regs = '0;
    cur_stat = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_hit[c]) begin
        cur_regs = bank_regs[c];
        cur_stat = bank_stat[c];
      end
  end

  always_comb begin
    rd_val = '0;
    unique case (sel_i)
      4'(SEL_PRESENT): rd_val[NCH-1:0]     = '1;
      4'(SEL_QUEUED):  rd_val[NCH-1:0]     = queued_i;
      4'(SEL_RUNNING): rd_val[NCH-1:0]     = running_i;
      4'(SEL_IRQ):     rd_val[NCH-1:0]     = irq_i;
      4'(SEL_CSTAT):   rd_val[STAT_W-1:0]  = cur_stat;
      4'(SEL_UPERM):   rd_val[UPERM_W-1:0] = uperm_q;
      4'(SEL_CHNUM):   rd_val[CHNUM_W-1:0] = chnum_q;
      4'(SEL_CTRL), 4'(SEL_ISTART), 4'(SEL_ESTART), 4'(SEL_IEND), 4'(SEL_CTXID):
                       rd_val = cur_regs[bank_idx];
      default:         rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uperm_q <= '0;
      chnum_q <= '0;
    end else begin
      if (dec.wr_uperm) uperm_q <= wdata_i[UPERM_W-1:0];
      if (dec.wr_chnum) chnum_q <= wdata_i[CHNUM_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      trap_o  <= 1'b0;
      rdata_o <= '0;
      start_o <= '0;
      stop_o  <= '0;
      clr_o   <= '0;
    end else begin
      ack_o   <= req_i;
      trap_o  <= dec.trap;
      rdata_o <= (req_i && !write_i && !dec.trap) ? rd_val : '0;
      start_o <= dec.cmd_start ? ch_hit : '0;
      stop_o  <= dec.cmd_stop  ? ch_hit : '0;
      clr_o   <= dec.cmd_clear ? ch_hit : '0;
    end
  end

  initial begin
    if (NCH < 2 || NCH > (1 << CHNUM_W) || DATA_W < MIN_W)
      $error("dma_bank_regs: bad parameters");
  end
endmodule

// File: rtl/dma_bank_regs_chk.sv
module dma_bank_regs_chk #(
  parameter int NCH     = 2,
  parameter int CHNUM_W = 4,
  parameter int DATA_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              write_i,
  input logic              user_i,
  input logic [3:0]        sel_i,
  input logic              ack_o,
  input logic              trap_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NCH-1:0]    start_o,
  input logic [NCH-1:0]    stop_o,
  input logic [NCH-1:0]    clr_o
);
  // R2
  ack_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);

  // R2
  trap_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> rdata_o == '0);

  // R5
  strobe_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_o) && $onehot0(stop_o) && $onehot0(clr_o));

  // R5
  strobe_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|{start_o, stop_o, clr_o}) |-> ack_o && $countones({|start_o, |stop_o, |clr_o}) == 1);

  // R7
  ro_write_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && write_i && sel_i <= 4'd4) |=> trap_o);

  // R10
  user_glob_write_trap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && write_i && user_i && (sel_i == 4'd8 || sel_i == 4'd9)) |=> trap_o);

  // R11
  trap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> ack_o && start_o == '0 && stop_o == '0 && clr_o == '0);
endmodule

bind dma_bank_regs dma_bank_regs_chk #(.NCH(NCH), .CHNUM_W(CHNUM_W), .DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .write_i (write_i),
  .user_i  (user_i),
  .sel_i   (sel_i),
  .ack_o   (ack_o),
  .trap_o  (trap_o),
  .rdata_o (rdata_o),
  .start_o (start_o),
  .stop_o  (stop_o),
  .clr_o   (clr_o)
);

// File: tb/dma_bank_regs_test.sv
module dma_bank_regs_test;
  localparam int NCH = 2;
  localparam int DW  = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n = 1'b0;
  logic           req = 0, wr = 0, usr = 0;
  logic [3:0]     sel = '0;
  logic [DW-1:0]  wdata = '0;
  logic [NCH-1:0] queued = '0, running = '0, irq = '0, done_e = '0, err_e = '0;
  logic           ack, trap;
  logic [DW-1:0]  rdata;
  logic [NCH-1:0] start, stop, clr;

  dma_bank_regs #(.NCH(NCH), .CHNUM_W(4), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .write_i(wr), .user_i(usr),
    .sel_i(sel), .wdata_i(wdata), .queued_i(queued), .running_i(running),
    .irq_i(irq), .done_evt_i(done_e), .err_evt_i(err_e),
    .ack_o(ack), .trap_o(trap), .rdata_o(rdata),
    .start_o(start), .stop_o(stop), .clr_o(clr)
  );

  int checks = 0, errors = 0;
  string cur = "R1";

  // reference model
  int          m_chn, m_up;
  logic [31:0] m_rw [NCH][5];
  int          m_st [NCH];
  logic        e_ack, e_trap;
  logic [31:0] e_rdata;
  logic [NCH-1:0] e_start, e_stop, e_clr;

  always @(posedge clk or negedge rst_n) begin
    int s; bit ro, cmd, brw, glb, t; bit [NCH-1:0] clrv;
    if (!rst_n) begin
      m_chn = 0; m_up = 0;
      for (int c = 0; c < NCH; c++) begin
        m_st[c] = 0;
        for (int i = 0; i < 5; i++) m_rw[c][i] = 0;
      end
      e_ack = 0; e_trap = 0; e_rdata = 0; e_start = 0; e_stop = 0; e_clr = 0;
    end else begin
      e_ack = req; e_trap = 0; e_rdata = 0; e_start = 0; e_stop = 0; e_clr = 0;
      clrv = '0;
      if (req) begin
        s = int'(sel);
        ro = s <= 4; cmd = s >= 5 && s <= 7; brw = s >= 10 && s <= 14; glb = s == 8 || s == 9;
        t = (ro && wr) || (cmd && !wr) || s == 15;
        if ((s == 4 || cmd || brw) && m_chn >= NCH) t = 1;
        if (usr && ((ro && !m_up[1]) || (cmd && !m_up[0]) || (brw && wr && !m_up[2]) ||
                    (brw && !wr && !m_up[3]) || (glb && wr))) t = 1;
        e_trap = t;
        if (!t) begin
          if (wr) begin
            if (s == 8) m_up = int'(wdata[3:0]);
            if (s == 9) m_chn = int'(wdata[3:0]);
            if (s == 5) e_start[m_chn] = 1;
            if (s == 6) e_stop[m_chn] = 1;
            if (s == 7) begin e_clr[m_chn] = 1; clrv[m_chn] = 1; end
            if (brw) m_rw[m_chn][s-10] = wdata;
          end else begin
            case (s)
              0: e_rdata = (1 << NCH) - 1;
              1: e_rdata = 32'(queued);
              2: e_rdata = 32'(running);
              3: e_rdata = 32'(irq);
              4: e_rdata = m_st[m_chn];
              8: e_rdata = m_up;
              9: e_rdata = m_chn;
              default: e_rdata = m_rw[m_chn][s-10];
            endcase
          end
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (clrv[c]) m_st[c] = 0;
        m_st[c] = m_st[c] | (done_e[c] ? 1 : 0) | (err_e[c] ? 2 : 0);
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string tg;
    tg = rst_n ? cur : "R1";
    chk(tg, "ack", 32'(ack), 32'(e_ack));
    chk(tg, "trap", 32'(trap), 32'(e_trap));
    chk(tg, "rdata", rdata, e_rdata);
    chk(tg, "start", 32'(start), 32'(e_start));
    chk(tg, "stop", 32'(stop), 32'(e_stop));
    chk(tg, "clr", 32'(clr), 32'(e_clr));
  end

  task automatic acc(bit w, int s, logic [31:0] d, bit u,
                     logic [NCH-1:0] dn = '0, logic [NCH-1:0] er = '0);
    @(posedge clk); #2;
    req = 1; wr = w; sel = 4'(s); wdata = d; usr = u; done_e = dn; err_e = er;
    @(posedge clk); #2;
    req = 0; wr = 0; usr = 0; done_e = '0; err_e = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3); #2; rst_n = 1;
    cur = "R1";
    acc(0, 8, 0, 0); acc(0, 9, 0, 0); acc(0, 10, 0, 0); acc(0, 14, 0, 0); acc(0, 4, 0, 0);

    cur = "R2";
    acc(1, 10, 32'h0000_1234, 0); acc(0, 10, 0, 0);
    acc(1, 11, 32'h1000_0040, 0); acc(0, 11, 0, 0);

    cur = "R3";
    acc(1, 9, 1, 0);
    acc(1, 10, 32'hA5A5_A5A5, 0); acc(1, 12, 32'h8000_0000, 0);
    acc(1, 13, 32'h1000_0FFC, 0); acc(1, 14, 32'h0000_00C3, 0);
    acc(0, 10, 0, 0); acc(0, 13, 0, 0);
    acc(1, 9, 0, 0);
    acc(0, 10, 0, 0); acc(0, 12, 0, 0); acc(0, 14, 0, 0); acc(0, 9, 0, 0);

    cur = "R4";
    queued = 2'b10; running = 2'b01; irq = 2'b11;
    acc(0, 0, 0, 0); acc(0, 1, 0, 0); acc(0, 2, 0, 0); acc(0, 3, 0, 0);
    queued = 2'b01; running = 2'b10; irq = 2'b00;
    acc(0, 1, 0, 0); acc(0, 2, 0, 0); acc(0, 3, 0, 0);

    cur = "R5";
    acc(1, 9, 1, 0);
    acc(1, 5, 32'hFFFF_FFFF, 0); acc(1, 6, 0, 0); acc(1, 7, 0, 0);
    acc(1, 9, 0, 0);
    acc(1, 5, 0, 0); acc(1, 6, 0, 0);

    cur = "R6";
    acc(0, 4, 0, 0, 2'b01);
    acc(0, 4, 0, 0);
    acc(0, 4, 0, 0, 2'b00, 2'b01);
    acc(0, 4, 0, 0);
    acc(1, 9, 1, 0); acc(0, 4, 0, 0); acc(1, 9, 0, 0);
    acc(1, 7, 0, 0, 2'b01);
    acc(0, 4, 0, 0);
    acc(1, 7, 0, 0);
    acc(0, 4, 0, 0);

    cur = "R7";
    acc(1, 2, 32'h5, 0); acc(1, 4, 32'h3, 0); acc(0, 4, 0, 0);
    acc(0, 6, 0, 0); acc(0, 5, 0, 0);
    acc(0, 15, 0, 0); acc(1, 15, 32'h1, 0);

    cur = "R8";
    acc(1, 9, 2, 0);
    acc(0, 10, 0, 0); acc(1, 10, 32'hDEAD_BEEF, 0); acc(1, 5, 0, 0); acc(0, 4, 0, 0);
    acc(0, 0, 0, 0); acc(0, 9, 0, 0);
    acc(1, 9, 15, 0); acc(1, 7, 0, 0);
    acc(1, 9, 0, 0); acc(0, 10, 0, 0);

    cur = "R9";
    acc(0, 1, 0, 1); acc(1, 5, 0, 1); acc(1, 10, 32'h77, 1); acc(0, 10, 0, 1);
    acc(1, 8, 32'h1, 0);
    acc(1, 5, 0, 1); acc(0, 1, 0, 1); acc(0, 10, 0, 1);
    acc(1, 8, 32'h2, 0);
    acc(0, 1, 0, 1); acc(0, 4, 0, 1); acc(1, 6, 0, 1);
    acc(1, 8, 32'h4, 0);
    acc(1, 11, 32'h2000_0000, 1); acc(0, 11, 0, 1);
    acc(1, 8, 32'h8, 0);
    acc(0, 11, 0, 1); acc(1, 11, 32'h3000_0000, 1); acc(0, 11, 0, 1);
    acc(1, 8, 32'hF, 0);
    acc(1, 7, 0, 1); acc(0, 3, 0, 1);

    cur = "R10";
    acc(1, 9, 1, 1); acc(1, 8, 0, 1);
    acc(0, 9, 0, 1); acc(0, 8, 0, 1);
    acc(0, 10, 0, 1);

    cur = "R11";
    acc(1, 8, 32'h0, 0);
    acc(1, 10, 32'hBAD0_BAD0, 1); acc(1, 7, 0, 1);
    acc(0, 10, 0, 0); acc(0, 8, 0, 0);
    acc(1, 0, 32'hFF, 0); acc(0, 0, 0, 0);
    idle(2);
    finish_run();
  end
endmodule